// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block turns one presented word address into the sequence of internal memory addresses for a burst of up to four data beats. In each enabled command cycle it either captures a new external address or steps an internal two-bit beat counter. The output address keeps the upper bits of the captured address. Its two lowest bits follow the beat sequence that the order-select input picks.

A select input qualifies every load. A load cycle with the select input low ends the current burst. Step requests that follow it are then ignored until the next selected load. A low clock-enable freezes every register, so a burst can be paused for any number of cycles and resumed. The output address is registered. It changes on the clock edge that follows the command cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: After synchronous reset, `mem_addr` is all zeros and no burst is live. A step request before the first selected load leaves `mem_addr` at zero.
- R2: In a cycle with `clk_en`=1, `adv_not_load`=0 and `chip_sel`=1, `mem_addr` equals `ext_addr` after the next rising edge. That value is beat 0.
- R3: With `order_xor`=0, each enabled step (`adv_not_load`=1) in a live burst sets `mem_addr[1:0]` to (start + beat) mod 4. From a start of 1 this gives 2, 3, 0, 1.
- R4: With `order_xor`=1, each enabled step sets `mem_addr[1:0]` to start XOR beat, where beat counts 1, 2, 3, 0. From a start of 2 this gives 3, 0, 1, 2.
- R5: `mem_addr[ADDR_W-1:2]` does not change during steps. The fourth step returns `mem_addr` to the loaded address.
- R6: While `clk_en`=0, `mem_addr` and the beat counter hold, whatever the other inputs do. After the pause, the next enabled step continues with the following beat.
- R7: A load cycle with `chip_sel`=0 (and `clk_en`=1) leaves `mem_addr` unchanged and ends the burst. Steps after it leave `mem_addr` unchanged.
- R8: A selected load during a live burst restarts at beat 0 of the new address. Later steps follow from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable, active high; low freezes all state |
| adv_not_load | input | 1 | 0 = load a new address, 1 = step the burst |
| chip_sel | input | 1 | Select for load cycles, active high |
| order_xor | input | 1 | Beat order: 0 = linear, 1 = interleaved (XOR) |
| ext_addr | input | ADDR_W | External word address |
| mem_addr | output | ADDR_W | Registered internal memory address |

## Verification
A wrong beat counter or start value shows up in `mem_addr[1:0]` one edge after the step that uses it. A linear sequence therefore fails at the first step, and an interleaved one fails by the second step at the latest. A live flag stuck high or low shows within one cycle of the first step after a deselect or a fresh load. A corrupted upper register shows on the very next step. A clock-enable leak is caught at the first paused edge, and again by the beat that follows the pause.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  // Low address bits for a given beat index and start offset.
  function automatic beat_t beat_low(input beat_t start, input beat_t idx, input logic use_xor);
    beat_t r;
    if (use_xor) r = start ^ idx;
    else         r = start + idx;
    return r;
  endfunction
endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  take_load,
  input  logic  take_desel,
  input  logic  take_step,
  output logic  live,
  output beat_t beat,
  output beat_t beat_nxt
);
  assign beat_nxt = beat + beat_t'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= 1'b0;
      beat <= '0;
    end else if (take_load) begin
      live <= 1'b1;
      beat <= '0;
    end else if (take_desel) begin
      live <= 1'b0;
    end else if (take_step && live) begin
      beat <= beat_nxt;
    end
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
(
  input  beat_t start_lo,
  input  beat_t idx,
  input  logic  use_xor,
  output beat_t low_out
);
  always_comb low_out = beat_low(start_lo, idx, use_xor);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              adv_not_load,
  input  logic              chip_sel,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic        do_load, do_desel, do_step;
  logic        burst_live;
  beat_t       beat_q, beat_nxt, next_lo;
  logic [ADDR_W-1:0] base_q;

  assign do_load  = clk_en && !adv_not_load && chip_sel;
  assign do_desel = clk_en && !adv_not_load && !chip_sel;
  assign do_step  = clk_en && adv_not_load;

  burst_beat_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .take_load  (do_load),
    .take_desel (do_desel),
    .take_step  (do_step),
    .live       (burst_live),
    .beat       (beat_q),
    .beat_nxt   (beat_nxt)
  );

  burst_order_map u_map (
    .start_lo (base_q[BEAT_W-1:0]),
    .idx      (beat_nxt),
    .use_xor  (order_xor),
    .low_out  (next_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      mem_addr <= '0;
    end else if (do_load) begin
      base_q   <= ext_addr;
      mem_addr <= ext_addr;
    end else if (do_step && burst_live) begin
      mem_addr <= {base_q[ADDR_W-1 -: HI_W], next_lo};
    end
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              adv_not_load,
  input logic              chip_sel,
  input logic              order_xor,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              burst_live
);
  a_r2_load_captures: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !adv_not_load && chip_sel) |=> (mem_addr == $past(ext_addr)));

  a_r6_enable_low_holds: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(mem_addr));

  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv_not_load) |=> $stable(mem_addr[ADDR_W-1:2]));

  a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv_not_load && burst_live && !order_xor)
      |=> (mem_addr[1:0] == 2'($past(mem_addr[1:0]) + 2'd1)));

  a_r7_idle_step_ignored: assert property (@(posedge clk) disable iff (rst)
    (clk_en && adv_not_load && !burst_live) |=> $stable(mem_addr));

  a_r7_desel_holds: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !adv_not_load && !chip_sel) |=> ($stable(mem_addr) && !burst_live));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .clk_en       (clk_en),
  .adv_not_load (adv_not_load),
  .chip_sel     (chip_sel),
  .order_xor    (order_xor),
  .ext_addr     (ext_addr),
  .mem_addr     (mem_addr),
  .burst_live   (burst_live)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst, clk_en, adv_not_load, chip_sel, order_xor;
  logic [AW-1:0] ext_addr, mem_addr;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .clk_en(clk_en), .adv_not_load(adv_not_load),
    .chip_sel(chip_sel), .order_xor(order_xor), .ext_addr(ext_addr),
    .mem_addr(mem_addr)
  );

  // Drive one cycle at the falling edge, then sample just after the rising edge.
  task automatic cyc(input logic ce, input logic adv, input logic sel,
                     input logic ox, input logic [AW-1:0] a);
    @(negedge clk);
    clk_en = ce; adv_not_load = adv; chip_sel = sel; order_xor = ox; ext_addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (mem_addr !== exp) begin
      errors++;
      $display("FAIL %s: mem_addr=%h expected=%h", req, mem_addr, exp);
    end
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] s, input int k, input logic ox);
    logic [1:0] lo;
    lo = ox ? (s[1:0] ^ 2'(k)) : 2'(s[1:0] + 2'(k));
    return {s[AW-1:2], lo};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
    rst = 1'b0;
    check("R1 reset value", '0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 18'h3FFFF);
    check("R1 step before load", '0);
  endtask

  task automatic t_linear();
    logic [AW-1:0] s = 18'h2AAA5;
    cyc(1'b1, 1'b0, 1'b1, 1'b0, s);
    check("R2 load linear", s);
    for (int k = 1; k <= 4; k++) begin
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 18'h00000);
      check(k == 4 ? "R5 linear wrap" : "R3 linear beat", beat_addr(s, k, 1'b0));
    end
  endtask

  task automatic t_interleave();
    logic [AW-1:0] s = 18'h1F00E;
    cyc(1'b1, 1'b0, 1'b1, 1'b1, s);
    check("R2 load interleaved", s);
    for (int k = 1; k <= 4; k++) begin
      cyc(1'b1, 1'b1, 1'b1, 1'b1, 18'h3FFFF);
      check(k == 4 ? "R5 interleaved wrap" : "R4 interleaved beat", beat_addr(s, k, 1'b1));
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] s = 18'h0C3F7;
    cyc(1'b1, 1'b0, 1'b1, 1'b0, s);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0);
    check("R6 pre-pause beat", beat_addr(s, 1, 1'b0));
    cyc(1'b0, 1'b1, 1'b1, 1'b0, '0);
    check("R6 hold on step", beat_addr(s, 1, 1'b0));
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 18'h12345);
    check("R6 hold on load", beat_addr(s, 1, 1'b0));
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 18'h00001);
    check("R6 hold on deselect", beat_addr(s, 1, 1'b0));
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0);
    check("R6 resume next beat", beat_addr(s, 2, 1'b0));
  endtask

  task automatic t_desel();
    logic [AW-1:0] s = 18'h25551;
    cyc(1'b1, 1'b0, 1'b1, 1'b1, s);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, '0);
    check("R7 beat before deselect", beat_addr(s, 1, 1'b1));
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 18'h3C3C3);
    check("R7 deselect load ignored", beat_addr(s, 1, 1'b1));
    cyc(1'b1, 1'b1, 1'b1, 1'b1, '0);
    check("R7 step after deselect", beat_addr(s, 1, 1'b1));
    cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
    check("R7 second step after deselect", beat_addr(s, 1, 1'b1));
  endtask

  task automatic t_reload();
    logic [AW-1:0] a = 18'h00102;
    logic [AW-1:0] b = 18'h3FF03;
    cyc(1'b1, 1'b0, 1'b1, 1'b0, a);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0);
    check("R8 mid-burst beat", beat_addr(a, 2, 1'b0));
    cyc(1'b1, 1'b0, 1'b1, 1'b0, b);
    check("R8 reload beat 0", b);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, '0);
    check("R8 beat 1 of new start", beat_addr(b, 1, 1'b0));
  endtask

  initial begin
    clk_en = 1'b0; adv_not_load = 1'b0; chip_sel = 1'b0; order_xor = 1'b0;
    ext_addr = '0; rst = 1'b1;
    t_reset();
    t_linear();
    t_interleave();
    t_hold();
    t_desel();
    t_reload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule